// File: doc/BRIEF.md
# Programmable Input Qualification Filter

This block cleans up a slow asynchronous digital input, such as a timer-direction or capture pin, before on-chip logic uses it. The raw pin first passes through a two-stage synchroniser. The synchronised level is then sampled on a programmable grid. The qualified output moves to a new level only when the six most recent samples agree on that level. When the level disagrees, the output keeps its old value.

The 8-bit period setting `n` places consecutive samples `2n` clock cycles apart. Each change of the synchronised level takes a sample in that same cycle and restarts the sampling phase. A pulse is therefore accepted when, and only when, it lasts at least `10n+1` synchronised cycles. For `n = 1` the threshold is 11 cycles. At `n = 255` one window is 510 cycles. A setting of zero bypasses qualification.

A small state machine holds the qualified level. It has three states:
- `ST_HOLD_LO`: the output is held low.
- `ST_HOLD_HI`: the output is held high.
- `ST_BYPASS`: the output follows the synchroniser.

The transitions are:
- `ST_HOLD_LO` to `ST_HOLD_HI` on a sample that completes six ones.
- `ST_HOLD_HI` to `ST_HOLD_LO` on a sample that completes six zeros.
- Any state to `ST_BYPASS` whenever the period field is zero.
- `ST_BYPASS` back to the hold state that matches the present output, once the field becomes nonzero.

Top module: `input_qual_filter`

## Requirements
- R1: With the period field at 0, `pin_qual` equals the level `pin_raw` had three rising clock edges earlier. This latency comes from two synchroniser flops plus the output register.
- R2: With the period field at a nonzero value `n` (8 bits, 1 to 255), and with the synchronised level unchanged, samples are taken every `2n` clock cycles.
- R3: A change of the synchronised level takes a sample in that same cycle and restarts the sampling grid from that cycle.
- R4: For nonzero `n`, the output takes a new level only once six consecutive samples equal it. For a clean step on `pin_raw`, the output follows after exactly `10n+3` rising edges.
- R5: For nonzero `n`, a pulse lasting `10n` or fewer clock cycles is rejected. A pulse lasting `10n+1` or more cycles is recognised (11 cycles when `n = 1`).
- R6: When the last six samples do not all agree, `pin_qual` keeps its previous value.
- R7: While `rst_n` is low, the output, the sample history and the period counter are all cleared to 0.
- R8: When the period field changes, the sampling counter restarts from zero on the next clock, and the first new-grid sample falls `2n` cycles after that. Samples already in the history are kept.
- R9: At the largest setting, 255, one window is 510 cycles, and a step is followed after 2553 edges.
- R10: Falling steps are qualified in the same way as rising ones, with the same latency and the same rejection of short low pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_raw | input | 1 | Unsynchronised input pin |
| qual_period | input | 8 | Sampling period setting `n`; 0 selects bypass |
| pin_qual | output | 1 | Qualified level |

## Verification
On every cycle, the assertions check four things:
- The period counter never runs past its `2n` limit.
- Each sample lands in the history.
- The output never moves without a sample in the qualified modes.
- Every qualified rise or fall is backed by a history of six agreeing samples, and the bypass path tracks the synchroniser one cycle behind.

Only the bench scenarios can show the end-to-end latencies and the exact pulse-width threshold. The bench sweeps that threshold over every width around `10n+1` for several periods. The scenarios also cover the effect of a mid-flight period change, and whether reset really discards the history.

// File: rtl/iqf_pkg.sv
package iqf_pkg;

    typedef enum logic [1:0] {
        ST_HOLD_LO = 2'd0,
        ST_HOLD_HI = 2'd1,
        ST_BYPASS  = 2'd2
    } iqf_state_e;

endpackage

// File: rtl/iqf_sync.sv
module iqf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/iqf_tick_gen.sv
module iqf_tick_gen #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] period,
    input  logic          level_chg,
    output logic          tick,
    output logic          bypass
);
    localparam int CW = PW + 2;

    logic [PW-1:0] period_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;
    logic          period_chg;

    assign limit      = {1'b0, period, 1'b0};
    assign bypass     = (period == '0);
    assign period_chg = (period != period_q);
    assign tick       = !bypass && (level_chg || (!period_chg && cnt_q == limit));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_q <= '0;
            cnt_q    <= '0;
        end else begin
            period_q <= period;
            if (bypass || period_chg) begin
                cnt_q <= '0;
            end else if (tick) begin
                cnt_q <= CW'(1);
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R2: the counter never passes the 2n boundary while the period is steady
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && !period_chg) |-> (cnt_q <= limit));

    // R8: a new period setting restarts the count
    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (period_chg && !bypass) |=> (cnt_q == '0 || tick));

endmodule

// File: rtl/iqf_history.sv
module iqf_history #(
    parameter int DEPTH = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift,
    input  logic din,
    output logic agree_hi_nxt,
    output logic agree_lo_nxt,
    output logic agree_hi,
    output logic agree_lo
);
    logic [DEPTH-1:0] hist_q;
    logic [DEPTH-1:0] hist_nxt;

    assign hist_nxt     = {hist_q[DEPTH-2:0], din};
    assign agree_hi_nxt = &hist_nxt;
    assign agree_lo_nxt = ~|hist_nxt;
    assign agree_hi     = &hist_q;
    assign agree_lo     = ~|hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (shift) begin
            hist_q <= hist_nxt;
        end
    end

    // R3: every sample taken lands as the newest history entry
    p_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        shift |=> (hist_q[0] == $past(din)));

    // R6: no sample, no history movement
    p_hist_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !shift |=> $stable(hist_q));

endmodule

// File: rtl/input_qual_filter.sv
module input_qual_filter #(
    parameter int PERIOD_W    = 8,
    parameter int SYNC_STAGES = 2,
    parameter int SAMPLES     = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pin_raw,
    input  logic [PERIOD_W-1:0] qual_period,
    output logic                pin_qual
);
    import iqf_pkg::*;

    logic       sync_lvl;
    logic       sync_lvl_d;
    logic       level_chg;
    logic       tick;
    logic       bypass;
    logic       agree_hi_nxt;
    logic       agree_lo_nxt;
    logic       agree_hi;
    logic       agree_lo;
    logic       out_q;
    iqf_state_e state_q;
    iqf_state_e state_d;

    iqf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_raw),
        .q_sync  (sync_lvl)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_lvl_d <= 1'b0;
        end else begin
            sync_lvl_d <= sync_lvl;
        end
    end

    assign level_chg = (sync_lvl != sync_lvl_d);

    iqf_tick_gen #(.PW(PERIOD_W)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .period    (qual_period),
        .level_chg (level_chg),
        .tick      (tick),
        .bypass    (bypass)
    );

    iqf_history #(.DEPTH(SAMPLES)) u_hist (
        .clk          (clk),
        .rst_n        (rst_n),
        .shift        (tick),
        .din          (sync_lvl),
        .agree_hi_nxt (agree_hi_nxt),
        .agree_lo_nxt (agree_lo_nxt),
        .agree_hi     (agree_hi),
        .agree_lo     (agree_lo)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD_LO: if (tick && agree_hi_nxt) state_d = ST_HOLD_HI;
            ST_HOLD_HI: if (tick && agree_lo_nxt) state_d = ST_HOLD_LO;
            ST_BYPASS:  state_d = out_q ? ST_HOLD_HI : ST_HOLD_LO;
            default:    state_d = ST_HOLD_LO;
        endcase
        if (bypass) begin
            state_d = ST_BYPASS;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD_LO;
        end else begin
            state_q <= state_d;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= 1'b0;
        end else if (state_d == ST_BYPASS) begin
            out_q <= sync_lvl;
        end else begin
            out_q <= (state_d == ST_HOLD_HI);
        end
    end

    assign pin_qual = out_q;

    // R6: without a sample, a qualified output cannot move
    p_hold_no_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !bypass) |=> $stable(pin_qual));

    // R4: a qualified rise is backed by six agreeing ones
    p_rise_agreed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pin_qual) && !$past(bypass)) |-> agree_hi);

    // R10: a qualified fall is backed by six agreeing zeros
    p_fall_agreed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pin_qual) && !$past(bypass)) |-> agree_lo);

    // R1: bypass output trails the synchroniser by one register
    p_bypass_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |=> (pin_qual == $past(sync_lvl)));

endmodule

// File: tb/input_qual_filter_tb.sv
module input_qual_filter_tb;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       pin_raw;
    logic [7:0] qual_period;
    logic       pin_qual;

    int n_cmp  = 0;
    int n_bad  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    input_qual_filter u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_raw     (pin_raw),
        .qual_period (qual_period),
        .pin_qual    (pin_qual)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: pin_qual=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic settle(input int cycles);
        repeat (cycles) @(negedge clk);
    endtask

    // clean step to lvl; output must follow after exactly 10n+3 rising edges
    task automatic step_latency(input int n, input logic lvl, input string req);
        @(negedge clk);
        pin_raw = lvl;
        repeat (10 * n + 2) @(posedge clk);
        @(negedge clk);
        chk(req, pin_qual, !lvl);
        @(posedge clk);
        @(negedge clk);
        chk(req, pin_qual, lvl);
    endtask

    initial begin
        rst_n       = 1'b0;
        pin_raw     = 1'b0;
        qual_period = 8'd0;
        settle(3);
        chk("R7", pin_qual, 1'b0);
        rst_n = 1'b1;
        settle(4);

        // R1: bypass latency and pulse shapes
        step_latency(0, 1'b1, "R1");
        step_latency(0, 1'b0, "R1");
        for (int w = 1; w <= 3; w++) begin
            @(negedge clk);
            pin_raw = 1'b1;
            for (int i = 1; i <= w + 4; i++) begin
                @(negedge clk);
                if (i == w) pin_raw = 1'b0;
                chk("R1", pin_qual, (i >= 3) && (i <= w + 2));
            end
        end

        // R4 / R10 step latencies for small periods
        for (int n = 1; n <= 2; n++) begin
            qual_period = 8'(n);
            settle(15 * n + 10);
            step_latency(n, 1'b1, "R4");
            settle(15 * n + 10);
            step_latency(n, 1'b0, "R10");
            settle(15 * n + 10);
        end

        // R9: largest setting
        qual_period = 8'd255;
        settle(20);
        step_latency(255, 1'b1, "R9");
        settle(3100);
        step_latency(255, 1'b0, "R9");
        settle(3100);

        // R3, R5, R2: width sweep around the 10n+1 threshold
        for (int n = 1; n <= 3; n++) begin
            qual_period = 8'(n);
            settle(15 * n + 10);
            for (int w = 1; w <= 10 * n + 3; w++) begin
                logic seen;
                seen = 1'b0;
                @(negedge clk);
                pin_raw = 1'b1;
                for (int i = 1; i <= 10 * n + w + 6; i++) begin
                    @(negedge clk);
                    if (i == w) pin_raw = 1'b0;
                    if (pin_qual) seen = 1'b1;
                end
                chk("R3,R5", seen, (w >= 10 * n + 1));
                settle(10 * n + 12);
                chk("R10", pin_qual, 1'b0);
            end
        end

        // R6: disagreeing samples hold the output
        qual_period = 8'd1;
        settle(20);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); pin_raw = 1'b1;
            settle(3);
            @(negedge clk); pin_raw = 1'b0;
            settle(2);
        end
        settle(2);
        chk("R6", pin_qual, 1'b0);
        @(negedge clk); pin_raw = 1'b1;
        settle(30);
        chk("R6", pin_qual, 1'b1);
        begin
            logic dropped;
            dropped = 1'b0;
            for (int k = 0; k < 3; k++) begin
                @(negedge clk); pin_raw = 1'b0;
                for (int i = 0; i < 6; i++) begin
                    @(negedge clk);
                    if (!pin_qual) dropped = 1'b1;
                end
                pin_raw = 1'b1;
                for (int i = 0; i < 4; i++) begin
                    @(negedge clk);
                    if (!pin_qual) dropped = 1'b1;
                end
            end
            chk("R6", dropped, 1'b0);
        end
        @(negedge clk); pin_raw = 1'b0;
        settle(40);
        chk("R10", pin_qual, 1'b0);

        // R8: period change mid-qualification keeps the history
        @(negedge clk);
        pin_raw = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        qual_period = 8'd2;
        repeat (21) @(posedge clk);
        @(negedge clk);
        chk("R8", pin_qual, 1'b0);
        @(posedge clk);
        @(negedge clk);
        chk("R8", pin_qual, 1'b1);

        // R7: reset mid-run clears output and history
        qual_period = 8'd1;
        settle(20);
        chk("R7", pin_qual, 1'b1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R7", pin_qual, 1'b0);
        settle(2);
        rst_n = 1'b1;
        repeat (12) @(posedge clk);
        @(negedge clk);
        chk("R7", pin_qual, 1'b0);
        @(posedge clk);
        @(negedge clk);
        chk("R7", pin_qual, 1'b1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not end, actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule